// File: doc/BRIEF.md
# RMII Receive Dibit and Carrier/Data-Valid Generator

This block sits on the PHY side of a reduced media-independent interface. It takes received nibbles, each marked by a valid strobe, together with a carrier-present flag. It turns them into the two-bit receive data bus and the combined carrier-sense/data-valid line that a MAC samples. Every output is registered on the single 50 MHz reference clock. Each nibble leaves as two dibits, with the low dibit first. A speed input picks between 100 Mb/s, where each dibit occupies one clock, and 10 Mb/s, where each dibit occupies a slot of ten clocks.

Nibbles pass through a small queue, so data can still be waiting after the carrier goes away. While that queue drains after carrier loss, the carrier/data-valid line is low on each first-dibit slot and high on each second-dibit slot. From this toggling the MAC can recover both the end of carrier and the end of valid data. A carrier with no data, such as a false carrier, holds the line high with the data bus at zero for as long as the carrier lasts. A write into a full queue is dropped and sets a sticky overflow flag.

Top module: `rmii_rx_dibit_gen`

## Requirements
- R1: After reset, crs_dv is 0, rxd is 00 and overflow is 0.
- R2: When the block is idle and crs_in is high at a clock edge, crs_dv is 1 after that edge. rxd stays 00 until the first nibble from the queue is presented.
- R3: Each queued nibble is presented in arrival order as two dibits: bits [1:0] first, then bits [3:2]. At 100 Mb/s (speed_100 = 1) each dibit lasts one clock, and nibbles follow each other with no gap while the queue is non-empty.
- R4: At 10 Mb/s (speed_100 = 0), each dibit value and the crs_dv level that goes with it are held for exactly 10 consecutive clocks.
- R5: When crs_in is low at a first-dibit slot boundary and the queue is empty, crs_dv goes to 0 and rxd to 00 for that slot.
- R6: A nibble taken from the queue while crs_in is low is presented with crs_dv = 0 on its first dibit and crs_dv = 1 on its second dibit.
- R7: rxd is 00 whenever crs_dv is 0, except on the first-dibit slots covered by R6.
- R8: While crs_in stays high and no nibble is queued, crs_dv stays 1 and rxd stays 00.
- R9: The queue holds DEPTH (default 4) nibbles. A write when the queue is full, with no read in the same cycle, is dropped and sets overflow. overflow is cleared only by reset.
- R10: crs_dv falls only on a cycle that presents the first dibit of a nibble, or on a cycle where rxd is 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s; change only while idle |
| crs_in | input | 1 | Carrier present on the medium |
| nib_valid | input | 1 | nib_data holds a received nibble this cycle |
| nib_data | input | 4 | Received nibble |
| crs_dv | output | 1 | Carrier sense / data valid toward the MAC |
| rxd | output | 2 | Receive dibit toward the MAC |
| overflow | output | 1 | Sticky flag: a nibble was dropped on a full queue |

## Verification
A wrong queue pointer or count shows up at rxd within one nibble time: a dibit is repeated, skipped or out of order. The bench compares every cycle of each burst against the expected nibble sequence. A wrong dibit phase shifts the drain toggling of crs_dv by one slot, and it is caught on the first nibble read after carrier loss. A wrong slot counter at 10 Mb/s moves the slot edges by at least one clock, and the bench sees this on the first slot, because it checks each of the ten cycles of every slot. An overflow path that drops the wrong nibble changes the last delivered dibits of the overflow burst.

// File: rtl/rmii_rx_dibit_gen.sv
module rmii_rx_dibit_gen #(
  parameter int DEPTH    = 4,
  parameter int SLOW_DIV = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100,
  input  logic       crs_in,
  input  logic       nib_valid,
  input  logic [3:0] nib_data,
  output logic       crs_dv,
  output logic [1:0] rxd,
  output logic       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(SLOW_DIV);

  logic [3:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic [CW-1:0] cnt;
  logic          hi_pend;
  logic [1:0]    cur_hi;

  logic          tick, pop, push, full;
  logic [CW-1:0] slot_load;

  assign tick      = (cnt == '0);
  assign full      = (count == (AW+1)'(DEPTH));
  assign pop       = tick && !hi_pend && (count != '0);
  assign push      = nib_valid && (!full || pop);
  assign slot_load = speed_100 ? '0 : CW'(SLOW_DIV - 1);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= nib_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
      if (nib_valid && !push) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crs_dv  <= 1'b0;
      rxd     <= 2'b00;
      hi_pend <= 1'b0;
      cur_hi  <= 2'b00;
      cnt     <= '0;
    end else if (!tick) begin
      cnt <= cnt - 1'b1;
    end else if (hi_pend) begin
      rxd     <= cur_hi;
      crs_dv  <= 1'b1;
      hi_pend <= 1'b0;
      cnt     <= slot_load;
    end else if (pop) begin
      rxd     <= mem[rd_ptr][1:0];
      cur_hi  <= mem[rd_ptr][3:2];
      crs_dv  <= crs_in;
      hi_pend <= 1'b1;
      cnt     <= slot_load;
    end else if (crs_in) begin
      rxd    <= 2'b00;
      crs_dv <= 1'b1;
      cnt    <= slot_load;
    end else begin
      rxd    <= 2'b00;
      crs_dv <= 1'b0;
      cnt    <= '0;
    end
  end
endmodule

module rmii_rx_dibit_chk #(
  parameter int DEPTH    = 4,
  parameter int SLOW_DIV = 10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         speed_100,
  input logic                         crs_in,
  input logic                         crs_dv,
  input logic [1:0]                   rxd,
  input logic                         overflow,
  input logic                         hi_pend,
  input logic [$clog2(DEPTH):0]       count,
  input logic [$clog2(SLOW_DIV)-1:0]  cnt
);
  AST_DV_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (crs_in && !crs_dv && !hi_pend && cnt == '0) |=> crs_dv); // R2
  AST_SLOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!speed_100 && cnt != '0) |=> ($stable(crs_dv) && $stable(rxd))); // R4
  AST_SECOND_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_pend && cnt == '0) |=> crs_dv); // R6
  AST_RXD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!crs_dv && !hi_pend) |-> (rxd == 2'b00)); // R7
  AST_NO_OVERFLOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R9
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH)); // R9
  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(crs_dv) |-> (hi_pend || rxd == 2'b00)); // R10
endmodule

bind rmii_rx_dibit_gen rmii_rx_dibit_chk #(.DEPTH(DEPTH), .SLOW_DIV(SLOW_DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .crs_in(crs_in),
  .crs_dv(crs_dv), .rxd(rxd), .overflow(overflow),
  .hi_pend(hi_pend), .count(count), .cnt(cnt)
);

// File: tb/rmii_rx_dibit_gen_bench.sv
module rmii_rx_dibit_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100 = 1'b1;
  logic       crs_in = 1'b0;
  logic       nib_valid = 1'b0;
  logic [3:0] nib_data = 4'h0;
  logic       crs_dv;
  logic [1:0] rxd;
  logic       overflow;

  int checks = 0;
  int errors = 0;
  int j, m;
  logic [3:0] nb;
  logic [2:0] exp_v;

  always #5 clk = ~clk;

  rmii_rx_dibit_gen u_rmii_rx_dibit_gen (
    .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .crs_in(crs_in),
    .nib_valid(nib_valid), .nib_data(nib_data),
    .crs_dv(crs_dv), .rxd(rxd), .overflow(overflow)
  );

  function automatic logic [3:0] nib(input int seed, input int idx);
    return 4'((seed + 7 * idx + 1) & 15);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input string req, input int cyc, input logic [2:0] act, input logic [2:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %b expected %b", req, cyc, act, expv);
    end
  endtask

  task automatic idle(input int n);
    crs_in = 1'b0; nib_valid = 1'b0; nib_data = 4'h0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    #2;
    for (int i = 0; i < 3; i++) step();
    check("R1 reset", 0, {crs_dv, rxd}, 3'b000);
    check("R1 overflow", 0, {2'b00, overflow}, 3'b000);
    rst_n = 1'b1;
    idle(2);

    // R3 R6 R7: nibbles without carrier drain with toggling crs_dv
    for (int k = 1; k <= 14; k++) begin
      nib_valid = (k <= 6); nib_data = nib(3, k - 1);
      step();
      if (k == 1 || k == 14) exp_v = 3'b000;
      else begin
        j = k - 2; m = j / 2; nb = nib(3, m);
        exp_v = (j % 2) ? {1'b1, nb[3:2]} : {1'b0, nb[1:0]};
      end
      check("R3 R6 R7 drain", k, {crs_dv, rxd}, exp_v);
    end
    idle(4);

    // R2 R3 R6: carrier burst then carrier loss with data queued
    for (int k = 1; k <= 12; k++) begin
      crs_in = (k <= 6);
      nib_valid = (k >= 3 && k <= 6); nib_data = nib(9, k - 3);
      step();
      if (k <= 3) exp_v = 3'b100;
      else if (k == 12) exp_v = 3'b000;
      else begin
        j = k - 4; m = j / 2; nb = nib(9, m);
        exp_v = (j % 2) ? {1'b1, nb[3:2]} : {(m < 2), nb[1:0]};
      end
      check("R2 R3 R6 carrier", k, {crs_dv, rxd}, exp_v);
    end
    idle(4);

    // R8 R5: false carrier, then drop with empty queue
    for (int k = 1; k <= 8; k++) begin
      crs_in = (k <= 7);
      step();
      check("R8 R5 false carrier", k, {crs_dv, rxd}, (k <= 7) ? 3'b100 : 3'b000);
    end
    idle(4);

    // R4 R6: 10 Mb/s slots of ten clocks
    speed_100 = 1'b0;
    for (int k = 1; k <= 55; k++) begin
      crs_in = (k <= 11);
      nib_valid = (k <= 2); nib_data = nib(5, k - 1);
      step();
      case ((k - 1) / 10)
        0: exp_v = 3'b100;
        1: begin nb = nib(5, 0); exp_v = {1'b1, nb[1:0]}; end
        2: begin nb = nib(5, 0); exp_v = {1'b1, nb[3:2]}; end
        3: begin nb = nib(5, 1); exp_v = {1'b0, nb[1:0]}; end
        4: begin nb = nib(5, 1); exp_v = {1'b1, nb[3:2]}; end
        default: exp_v = 3'b000;
      endcase
      check("R4 R6 slow", k, {crs_dv, rxd}, exp_v);
    end
    idle(4);
    speed_100 = 1'b1;
    idle(2);

    // R9: ten back-to-back nibbles, the ninth is dropped
    for (int k = 1; k <= 20; k++) begin
      nib_valid = (k <= 10); nib_data = nib(11, k - 1);
      step();
      if (k == 1 || k == 20) exp_v = 3'b000;
      else begin
        j = k - 2; m = j / 2;
        nb = nib(11, (m < 8) ? m : 9);
        exp_v = (j % 2) ? {1'b1, nb[3:2]} : {1'b0, nb[1:0]};
      end
      check("R9 R3 overflow stream", k, {crs_dv, rxd}, exp_v);
      check("R9 overflow flag", k, {2'b00, overflow}, {2'b00, (k >= 9)});
    end
    idle(20);
    check("R9 overflow sticky", 0, {2'b00, overflow}, 3'b001);
    check("R7 idle bus", 0, {crs_dv, rxd}, 3'b000);
    rst_n = 1'b0;
    step();
    check("R1 reset clears overflow", 0, {crs_dv, rxd, overflow} == 4'b0000 ? 3'b000 : 3'b111, 3'b000);
    rst_n = 1'b1;
    idle(2);

    summary();
    $finish;
  end
endmodule